// File: doc/BRIEF.md
# Source-Synchronous ADC Capture Receiver

This block receives conversion results from a multi-channel successive-approximation converter over a source-synchronous serial link. The converter drives the data clock, the framing strobe and two serial data lanes, one lane for each of its two simultaneously sampling cores. The capture logic is clocked by the forwarded clock and never by a locally generated serial clock. Each lane is sampled on the rising edge of that clock and shifted into a 20-bit word.

From each word the receiver takes the 18-bit result and the two status bits. When the scrambling mode is active, it restores the true result by XORing every result bit above the LSB with the received LSB. Both lane results of a frame belong to the same sampling instant. They are stored together as one entry in a small asynchronous FIFO with Gray-coded pointers.

On the system-clock side the pair is emitted as two single-cycle results, lane 0 first. Each result carries a 3-bit channel tag. The tag is derived from the lane and from the frame's position in a four-frame sequence. If a frame completes while the FIFO is full, the frame is dropped and a sticky overflow flag is set.

Top module: `sscap_rx`

## Requirements
- R1: After reset, `out_valid` is low and `ovf` is low, and `out_valid` stays low while `rst` is held.
- R2: A word starts on the `dclk` rising edge where `frame` is high and spans 20 consecutive bits, most significant bit first. Word bits 19:2 carry the result and bits 1:0 carry the status. The status is presented unchanged on `out_sts`.
- R3: A high `frame` before 20 bits have been taken discards the partial word. This includes the edge that would carry bit 0 of the word. No output is produced for the discarded word, the sequence position does not advance, and a new word starts at that edge.
- R4: With scrambling off, `out_res` equals the received result bits.
- R5: With scrambling on, result bit 0 is passed unchanged and each result bit 17..1 is XORed with received result bit 0.
- R6: The scrambling mode is taken from `scr_en` only on the edge where `frame` is high. Changes of `scr_en` during the other 19 bits do not affect that word.
- R7: Completed frames are numbered 0,1,2,3,0,... from reset, and dropped frames are counted too. A lane 0 result has `out_ch` = number and a lane 1 result has `out_ch` = 4 + number.
- R8: Each frame yields exactly two outputs on consecutive `clk` cycles, lane 0 first, each with `out_valid` high for one cycle.
- R9: Results leave in arrival order, with none lost or invented. This holds also when frames follow each other with no idle bit between them.
- R10: The FIFO holds 4 frame pairs. A frame completing while it is full is dropped and `ovf` is set. `ovf` stays set until `rst_dclk`, and the stored pairs are still delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dclk | input | 1 | Forwarded data clock from the converter |
| rst_dclk | input | 1 | Synchronous active-high reset, `dclk` domain |
| frame | input | 1 | High on the first bit of each word |
| din | input | 2 | Serial data, one bit per lane |
| scr_en | input | 1 | Scrambling mode, taken at word start |
| ovf | output | 1 | Sticky overflow flag, `dclk` domain |
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset, `clk` domain |
| out_valid | output | 1 | One-cycle strobe per result |
| out_res | output | 18 | Restored conversion result |
| out_sts | output | 2 | Status bits of the word |
| out_ch | output | 3 | Channel tag |

## Verification
Word completion and a framing restart can land on the same `dclk` edge. This happens when `frame` rises in the slot that would carry bit 0 of the current word. The bench provokes it by sending 19 bits and then starting a new frame at once. It judges the case by the output stream: the next result must carry the new word's value and the same channel tag the discarded word would have used. A second collision is a frame completing while the FIFO is full. This is provoked by holding the system side in reset while five frames arrive. It is judged by `ovf` and by exactly four pairs appearing after release.

// File: rtl/sscap_pkg.sv
package sscap_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int WORD_W = 20;
    localparam int RES_W  = 18;
    localparam int STS_W  = WORD_W - RES_W;
    localparam int LANES  = 2;
    localparam int SEQ_W  = 2;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
    localparam int CH_W   = LANE_W + SEQ_W;

    typedef struct packed {
        logic [RES_W-1:0] res;
        logic [STS_W-1:0] sts;
    } sample_t;

    typedef struct packed {
        logic [SEQ_W-1:0]          seq;
        sample_t [LANES-1:0]       lane;
    } entry_t;

    // Undo the LSB-keyed XOR: bit 0 is the key and stays as received.
    function automatic logic [RES_W-1:0] unscramble(input logic [RES_W-1:0] r);
        return r ^ {{(RES_W-1){r[0]}}, 1'b0};
    endfunction
endpackage

// File: rtl/sscap_deser.sv
module sscap_deser
    import sscap_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    frame,
    input  logic    din,
    input  logic    scr_en,
    output logic    done,
    output sample_t sample
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-2:0] shreg;
    logic [CNT_W-1:0]  cnt;
    logic              busy;
    logic              scr_q;
    logic [WORD_W-1:0] word;
    logic [RES_W-1:0]  raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            scr_q <= 1'b0;
        end else if (frame) begin
            shreg <= {{(WORD_W-2){1'b0}}, din};
            cnt   <= CNT_W'(1);
            busy  <= 1'b1;
            scr_q <= scr_en;
        end else if (busy) begin
            shreg <= {shreg[WORD_W-3:0], din};
            if (cnt == LAST) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    assign done       = busy && !frame && (cnt == LAST);
    assign word       = {shreg, din};
    assign raw        = word[WORD_W-1:STS_W];
    assign sample.res = scr_q ? unscramble(raw) : raw;
    assign sample.sts = word[STS_W-1:0];

    // R2
    done_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
endmodule

// File: rtl/sscap_afifo.sv
module sscap_afifo #(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          wclk,
    input  logic          wrst,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    output logic          full,
    input  logic          rclk,
    input  logic          rrst,
    input  logic          ren,
    output logic [DW-1:0] rdata,
    output logic          empty
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [AW:0]   wbin, wgray, rg_w1, rg_w2;
    logic [AW:0]   rbin, rgray, wg_r1, wg_r2;
    logic [AW:0]   wbin_nx, rbin_nx;
    logic          do_w, do_r;

    assign wbin_nx = wbin + 1'b1;
    assign rbin_nx = rbin + 1'b1;
    assign do_w    = wen && !full;
    assign do_r    = ren && !empty;

    always_ff @(posedge wclk) begin
        if (do_w) mem[wbin[AW-1:0]] <= wdata;
    end

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin  <= '0;
            wgray <= '0;
            rg_w1 <= '0;
            rg_w2 <= '0;
        end else begin
            rg_w1 <= rgray;
            rg_w2 <= rg_w1;
            if (do_w) begin
                wbin  <= wbin_nx;
                wgray <= wbin_nx ^ (wbin_nx >> 1);
            end
        end
    end

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin  <= '0;
            rgray <= '0;
            wg_r1 <= '0;
            wg_r2 <= '0;
        end else begin
            wg_r1 <= wgray;
            wg_r2 <= wg_r1;
            if (do_r) begin
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
        end
    end

    assign full  = (wgray == {~rg_w2[AW:AW-1], rg_w2[AW-2:0]});
    assign empty = (rgray == wg_r2);
    assign rdata = mem[rbin[AW-1:0]];
endmodule

// File: rtl/sscap_rx.sv
module sscap_rx
    import sscap_pkg::*;
#(
    parameter int FIFO_AW = 2
) (
    input  logic             dclk,
    input  logic             rst_dclk,
    input  logic             frame,
    input  logic [LANES-1:0] din,
    input  logic             scr_en,
    output logic             ovf,
    input  logic             clk,
    input  logic             rst,
    output logic             out_valid,
    output logic [RES_W-1:0] out_res,
    output logic [STS_W-1:0] out_sts,
    output logic [CH_W-1:0]  out_ch
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int EW = $bits(entry_t);

    logic [LANES-1:0] done;
    sample_t          smp [LANES];
    logic             push, full, empty, ren;
    logic [SEQ_W-1:0] seq;
    entry_t           went, rent, hold;
    logic [EW-1:0]    rdata;
    logic [LANE_W-1:0] idx;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        sscap_deser u_deser (
            .clk    (dclk),
            .rst    (rst_dclk),
            .frame  (frame),
            .din    (din[l]),
            .scr_en (scr_en),
            .done   (done[l]),
            .sample (smp[l])
        );
    end

    assign push = &done;

    always_comb begin
        went.seq = seq;
        for (int l = 0; l < LANES; l++) went.lane[l] = smp[l];
    end

    always_ff @(posedge dclk) begin
        if (rst_dclk) begin
            seq <= '0;
            ovf <= 1'b0;
        end else if (push) begin
            seq <= seq + 1'b1;
            if (full) ovf <= 1'b1;
        end
    end

    sscap_afifo #(.DW(EW), .AW(FIFO_AW)) u_fifo (
        .wclk  (dclk),
        .wrst  (rst_dclk),
        .wen   (push),
        .wdata (went),
        .full  (full),
        .rclk  (clk),
        .rrst  (rst),
        .ren   (ren),
        .rdata (rdata),
        .empty (empty)
    );

    assign rent = rdata;
    assign ren  = !rst && (idx == '0) && !empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_res   <= '0;
            out_sts   <= '0;
            out_ch    <= '0;
            idx       <= '0;
            hold      <= '0;
        end else if (idx != '0) begin
            out_valid          <= 1'b1;
            {out_res, out_sts} <= hold.lane[idx];
            out_ch             <= {idx, hold.seq};
            idx                <= (idx == LANE_W'(LANES - 1)) ? '0 : idx + 1'b1;
        end else if (!empty) begin
            out_valid          <= 1'b1;
            {out_res, out_sts} <= rent.lane[0];
            out_ch             <= {LANE_W'(0), rent.seq};
            hold               <= rent;
            idx                <= (LANES > 1) ? LANE_W'(1) : '0;
        end else begin
            out_valid <= 1'b0;
        end
    end

    // R10
    ovf_set_chk: assert property (@(posedge dclk) disable iff (rst_dclk)
        (push && full) |=> ovf);
    // R10
    ovf_hold_chk: assert property (@(posedge dclk) disable iff (rst_dclk)
        ovf |=> ovf);
    // R8
    lane0_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ch[CH_W-1 -: LANE_W] == '0)
        |=> (out_valid && out_ch[CH_W-1 -: LANE_W] != '0));
    // R8
    pair_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_ch[CH_W-1 -: LANE_W] != '0)
        |-> ($past(out_valid) && $past(out_ch[SEQ_W-1:0]) == out_ch[SEQ_W-1:0]));
endmodule

// File: tb/sscap_rx_bench.sv
module sscap_rx_bench;
    timeunit 1ns;
    timeprecision 100ps;

    typedef struct {
        logic [17:0] res;
        logic [1:0]  sts;
        logic [2:0]  ch;
        string       tag;
    } exp_t;

    logic clk = 0, rst = 1, dclk = 0, rst_dclk = 1;
    logic frame = 0, scr_en = 0;
    logic [1:0] din = 0;
    logic ovf, out_valid;
    logic [17:0] out_res;
    logic [1:0]  out_sts;
    logic [2:0]  out_ch;

    exp_t q[$];
    int checks = 0, fails = 0, fseq = 0;
    bit finished = 0;
    logic prev_v = 0;

    always #2.5 clk = ~clk;
    initial begin
        #1.3;
        forever #5 dclk = ~dclk;
    end

    sscap_rx u_sscap_rx (
        .dclk(dclk), .rst_dclk(rst_dclk), .frame(frame), .din(din), .scr_en(scr_en),
        .ovf(ovf), .clk(clk), .rst(rst), .out_valid(out_valid),
        .out_res(out_res), .out_sts(out_sts), .out_ch(out_ch)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [17:0] scramble(input logic [17:0] v);
        logic [17:0] s = v;
        for (int i = 1; i < 18; i++) s[i] = v[i] ^ v[0];
        return s;
    endfunction

    always @(negedge clk) begin
        exp_t e;
        if (rst) begin
            prev_v = 0;
        end else begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(0, "R9", "unexpected output", 32'(out_res), 0);
                end else begin
                    e = q.pop_front();
                    chk(out_res == e.res, e.tag, "result", 32'(out_res), 32'(e.res));
                    chk(out_sts == e.sts, "R2", "status", 32'(out_sts), 32'(e.sts));
                    chk(out_ch == e.ch, "R7", "channel", 32'(out_ch), 32'(e.ch));
                end
                if (out_ch[2]) chk(prev_v, "R8", "lane1 follows lane0", 32'(prev_v), 1);
            end
            prev_v = out_valid;
        end
    end

    task automatic send_frame(input logic [17:0] v0, input logic [17:0] v1,
                              input logic [1:0] s0, input logic [1:0] s1,
                              input bit scr, input string tag, input bit keep);
        logic [19:0] w0, w1;
        w0 = {scr ? scramble(v0) : v0, s0};
        w1 = {scr ? scramble(v1) : v1, s1};
        if (keep) begin
            q.push_back('{v0, s0, {1'b0, 2'(fseq)}, tag});
            q.push_back('{v1, s1, {1'b1, 2'(fseq)}, tag});
        end
        fseq = (fseq + 1) % 4;
        for (int i = 0; i < 20; i++) begin
            @(negedge dclk);
            frame  = (i == 0);
            din    = {w1[19-i], w0[19-i]};
            scr_en = (i == 0) ? scr : ~scr;
        end
    endtask

    task automatic send_partial(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge dclk);
            frame  = (i == 0);
            din    = 2'($urandom);
            scr_en = 1'($urandom);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge dclk);
            frame  = 0;
            din    = 2'($urandom);
            scr_en = 1'($urandom);
        end
    endtask

    task automatic drain(input string req);
        repeat (150) @(negedge clk);
        chk(q.size() == 0, req, "pending results", 32'(q.size()), 0);
    endtask

    initial begin
        #200000;
        if (!finished) begin
            fails++;
            $display("FAIL R9 watchdog expired actual=%0d expected=0", q.size());
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge dclk);
        rst_dclk = 0;
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(out_valid == 0, "R1", "valid after reset", 32'(out_valid), 0);
        @(negedge dclk);
        chk(ovf == 0, "R1", "ovf after reset", 32'(ovf), 0);

        // plain mode, patterns and extremes (R2, R4)
        send_frame(18'h2AAAA, 18'h15555, 2'b01, 2'b10, 0, "R4", 1);
        idle(3);
        send_frame(18'h00000, 18'h3FFFF, 2'b11, 2'b00, 0, "R4", 1);
        idle(2);
        send_frame(18'h3FFFE, 18'h00001, 2'b10, 2'b01, 0, "R2", 1);
        idle(2);
        // scrambled mode, key bit 1 and 0 (R5); scr_en toggles mid-word (R6)
        send_frame(18'h12345, 18'h2F0F1, 2'b00, 2'b11, 1, "R5", 1);
        idle(2);
        send_frame(18'h1FFFE, 18'h20000, 2'b01, 2'b01, 1, "R5", 1);
        idle(2);
        send_frame(18'h0F0F3, 18'h30C30, 2'b10, 2'b10, 0, "R6", 1);
        idle(2);
        send_frame(18'h0F0F3, 18'h30C30, 2'b10, 2'b10, 1, "R6", 1);
        idle(2);
        drain("R9");

        // framing restart: short partial, and restart in the last-bit slot (R3)
        send_partial(7);
        send_frame(18'h0ABCD, 18'h3DCBA, 2'b01, 2'b10, 0, "R3", 1);
        idle(2);
        send_partial(19);
        send_frame(18'h11111, 18'h22222, 2'b11, 2'b01, 1, "R3", 1);
        idle(2);
        drain("R3");

        // sequence wrap (R7) then back-to-back random frames (R9)
        for (int k = 0; k < 5; k++)
            send_frame(18'($urandom), 18'($urandom), 2'($urandom), 2'($urandom), 0, "R7", 1);
        for (int k = 0; k < 8; k++)
            send_frame(18'($urandom), 18'($urandom), 2'($urandom), 2'($urandom),
                       1'($urandom), "R9", 1);
        idle(2);
        drain("R9");
        @(negedge dclk);
        chk(ovf == 0, "R10", "no overflow in normal flow", 32'(ovf), 0);

        // overflow: system side held in reset while five frames arrive (R10)
        @(negedge clk);
        rst = 1;
        @(negedge dclk);
        rst_dclk = 1;
        repeat (4) @(negedge dclk);
        rst_dclk = 0;
        fseq = 0;
        @(negedge dclk);
        chk(ovf == 0, "R1", "ovf after second reset", 32'(ovf), 0);
        for (int k = 0; k < 5; k++)
            send_frame(18'($urandom), 18'($urandom), 2'($urandom), 2'($urandom),
                       1'($urandom), "R10", (k < 4));
        idle(3);
        chk(ovf == 1, "R10", "ovf after drop", 32'(ovf), 1);
        @(negedge clk);
        chk(out_valid == 0, "R1", "valid held in reset", 32'(out_valid), 0);
        rst = 0;
        drain("R10");
        send_frame(18'h2468A, 18'h13579, 2'b10, 2'b11, 0, "R7", 1);
        idle(3);
        drain("R7");
        chk(ovf == 1, "R10", "ovf sticky", 32'(ovf), 1);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule